// File: doc/BRIEF.md
# Framed Serial Command Word Loader

This block sits between a write-only three-wire serial link and a numerically controlled oscillator core. A host lowers an active-low frame strobe and clocks 16-bit command words in, most significant bit first, one bit per falling edge of the serial clock. Each completed word is handed across to the core clock domain. There it is decoded by its two top bits into one of three targets: a control register, one of two 28-bit frequency registers, or one of two 12-bit phase registers.

A frequency register takes its 14-bit halves in one of two ways. In paired mode the low half is held in a staging register until a second write to the same address brings the high half. The 28-bit register is then written in one step. In split mode each write replaces only the half named by a control bit. The register contents and the decoded control fields leave the block as plain outputs for the oscillator core.

Top module: `cmdword_loader`

## Requirements
- R1: While `rst` is high at a core clock edge, all four tuning registers, every control field and the staging register are cleared to zero at that edge.
- R2: Bits are taken only on falling `ser_clk` edges while `ser_frame_n` is low, with the first bit as word bit 15. Serial clock edges while the strobe is high change nothing.
- R3: The strobe may stay low across any number of whole 16-bit words. Every 16th falling edge completes a word, and each completed word is applied.
- R4: Word bits 15:14 select the target: 00 is control, 01 is frequency register 0, 10 is frequency register 1, 11 is phase. For phase words, bit 13 selects phase register 1 when set and phase register 0 when clear, bit 12 is ignored, and bits 11:0 are loaded.
- R5: A control word sets these fields: bit 13 paired mode, bit 12 upper-half select, bit 11 frequency select, bit 10 phase select, bit 8 core reset, bit 7 clock sleep, bit 6 converter sleep, bit 5 bit-output enable, bit 3 divide-by-two select, bit 1 ramp mode. Bits 9, 4, 2 and 0 have no effect.
- R6: In paired mode, the first frequency write is staged as the low 14 bits and leaves every frequency register unchanged. The next write to the same address supplies bits 27:14 and loads all 28 bits at once.
- R7: In split mode, a frequency write with upper-half select set replaces bits 27:14. With it clear, the write replaces bits 13:0. The other half is kept in both cases.
- R8: In paired mode the upper-half select bit has no effect on how frequency words are taken.
- R9: If the strobe rises before 16 bits have arrived, the partial word is dropped. Counting restarts at bit 15 on the next frame.
- R10: A control write discards any staged low half. The next frequency write is then treated as a first half.
- R11: In paired mode, a write to the other frequency address while a half is staged replaces the staged half and starts a new pair for that address.
- R12: A phase write leaves a staged frequency half in place.
- R13: Each completed word changes the outputs exactly once, within six core clock cycles of its last serial edge. No output changes without a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, core domain |
| ser_clk | input | 1 | Serial clock, data taken on falling edge |
| ser_frame_n | input | 1 | Active-low frame strobe |
| ser_data | input | 1 | Serial data, MSB first |
| freq0_o | output | 28 | Frequency register 0 |
| freq1_o | output | 28 | Frequency register 1 |
| phase0_o | output | 12 | Phase register 0 |
| phase1_o | output | 12 | Phase register 1 |
| full_load_o | output | 1 | Paired-load mode |
| hi_half_o | output | 1 | Upper-half select for split mode |
| freq_sel_o | output | 1 | Frequency register select |
| phase_sel_o | output | 1 | Phase register select |
| core_rst_o | output | 1 | Oscillator reset request |
| clk_sleep_o | output | 1 | Clock sleep request |
| dac_sleep_o | output | 1 | Converter sleep request |
| bit_out_o | output | 1 | Digital bit output enable |
| div2_o | output | 1 | Divide-by-two select |
| ramp_o | output | 1 | Ramp mode select |

## Verification
The hardest state to reach from the ports is a staged low half that is still waiting when some other word arrives: a control word, a phase word, or a write to the other frequency address. Each of these must either keep or drop the staged half without touching the 28-bit registers. The stimulus builds these cases by streaming several words inside a single frame. Each word's expected register image is queued at its 16th falling edge. The bench then confirms that no frequency register moves until the pairing write arrives. Aborted frames and serial edges given with the strobe high are checked in the same way, against an unchanged image.

// File: rtl/cwl_pkg.sv
package cwl_pkg;

    localparam int WORD_W  = 16;
    localparam int FREQ_W  = 28;
    localparam int HALF_W  = FREQ_W / 2;
    localparam int PHASE_W = 12;
    localparam int CNT_W   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        DST_CTRL  = 2'b00,
        DST_FREQ0 = 2'b01,
        DST_FREQ1 = 2'b10,
        DST_PHASE = 2'b11
    } dest_e;

    typedef struct packed {
        logic full_load;
        logic hi_half;
        logic freq_sel;
        logic phase_sel;
        logic core_rst;
        logic clk_sleep;
        logic dac_sleep;
        logic bit_out;
        logic div2;
        logic ramp;
    } ctrl_t;

    function automatic dest_e word_dest(input logic [WORD_W-1:0] w);
        return dest_e'(w[WORD_W-1:WORD_W-2]);
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.full_load = w[13];
        c.hi_half   = w[12];
        c.freq_sel  = w[11];
        c.phase_sel = w[10];
        c.core_rst  = w[8];
        c.clk_sleep = w[7];
        c.dac_sleep = w[6];
        c.bit_out   = w[5];
        c.div2      = w[3];
        c.ramp      = w[1];
        return c;
    endfunction

endpackage

// File: rtl/cwl_serial_rx.sv
module cwl_serial_rx
    import cwl_pkg::*;
(
    input  logic              ser_clk,
    input  logic              ser_frame_n,
    input  logic              ser_data,
    output logic [WORD_W-1:0] word_q,
    output logic              word_tgl
);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] shreg;
    logic [WORD_W-1:0] assembled;
    logic              last_bit;

    assign assembled = {shreg, ser_data};
    assign last_bit  = (bit_cnt == CNT_W'(WORD_W - 1));

    // strobe high holds the counter at zero: partial words vanish
    always_ff @(negedge ser_clk or posedge ser_frame_n) begin
        if (ser_frame_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
            shreg   <= assembled[WORD_W-2:0];
        end
    end

    // completed word is parked here; the toggle announces it to the core
    always_ff @(negedge ser_clk) begin
        if (last_bit) begin
            word_q   <= assembled;
            word_tgl <= ~word_tgl;
        end
    end

endmodule

// File: rtl/cwl_toggle_sync.sv
module cwl_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // free-running chain: settles to the toggle level while rst is held
    always_ff @(posedge clk) begin
        chain <= {chain[CHAIN_W-2:0], tgl_in};
    end

    assign pulse = (chain[CHAIN_W-1] ^ chain[CHAIN_W-2]) & ~rst;

endmodule

// File: rtl/cwl_regfile.sv
module cwl_regfile
    import cwl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               apply,
    input  logic [WORD_W-1:0]  word,
    output ctrl_t              ctrl,
    output logic [FREQ_W-1:0]  freq  [2],
    output logic [PHASE_W-1:0] phase [2],
    output logic               pend_valid,
    output logic               pend_idx
);

    dest_e             dst;
    logic              fidx;
    logic [HALF_W-1:0] payload;
    logic [HALF_W-1:0] pend_lo;

    assign dst     = word_dest(word);
    assign fidx    = (dst == DST_FREQ1);
    assign payload = word[HALF_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            pend_valid <= 1'b0;
            pend_idx   <= 1'b0;
            pend_lo    <= '0;
            for (int i = 0; i < 2; i++) begin
                freq[i]  <= '0;
                phase[i] <= '0;
            end
        end else if (apply) begin
            unique case (dst)
                DST_CTRL: begin
                    ctrl       <= unpack_ctrl(word);
                    pend_valid <= 1'b0;
                end
                DST_PHASE: begin
                    phase[word[13]] <= word[PHASE_W-1:0];
                end
                default: begin
                    if (ctrl.full_load) begin
                        if (pend_valid && pend_idx == fidx) begin
                            freq[fidx] <= {payload, pend_lo};
                            pend_valid <= 1'b0;
                        end else begin
                            pend_lo    <= payload;
                            pend_idx   <= fidx;
                            pend_valid <= 1'b1;
                        end
                    end else if (ctrl.hi_half) begin
                        freq[fidx][FREQ_W-1:HALF_W] <= payload;
                    end else begin
                        freq[fidx][HALF_W-1:0] <= payload;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cmdword_loader.sv
module cmdword_loader
    import cwl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk,
    input  logic               ser_frame_n,
    input  logic               ser_data,
    output logic [FREQ_W-1:0]  freq0_o,
    output logic [FREQ_W-1:0]  freq1_o,
    output logic [PHASE_W-1:0] phase0_o,
    output logic [PHASE_W-1:0] phase1_o,
    output logic               full_load_o,
    output logic               hi_half_o,
    output logic               freq_sel_o,
    output logic               phase_sel_o,
    output logic               core_rst_o,
    output logic               clk_sleep_o,
    output logic               dac_sleep_o,
    output logic               bit_out_o,
    output logic               div2_o,
    output logic               ramp_o
);

    logic [WORD_W-1:0]  core_word;
    logic               word_tgl;
    logic               apply;
    ctrl_t              ctrl;
    logic [FREQ_W-1:0]  freq  [2];
    logic [PHASE_W-1:0] phase [2];
    logic               pend_valid;
    logic               pend_idx;

    cwl_serial_rx u_rx (
        .ser_clk     (ser_clk),
        .ser_frame_n (ser_frame_n),
        .ser_data    (ser_data),
        .word_q      (core_word),
        .word_tgl    (word_tgl)
    );

    cwl_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .tgl_in (word_tgl),
        .pulse  (apply)
    );

    cwl_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .apply      (apply),
        .word       (core_word),
        .ctrl       (ctrl),
        .freq       (freq),
        .phase      (phase),
        .pend_valid (pend_valid),
        .pend_idx   (pend_idx)
    );

    assign freq0_o     = freq[0];
    assign freq1_o     = freq[1];
    assign phase0_o    = phase[0];
    assign phase1_o    = phase[1];
    assign full_load_o = ctrl.full_load;
    assign hi_half_o   = ctrl.hi_half;
    assign freq_sel_o  = ctrl.freq_sel;
    assign phase_sel_o = ctrl.phase_sel;
    assign core_rst_o  = ctrl.core_rst;
    assign clk_sleep_o = ctrl.clk_sleep;
    assign dac_sleep_o = ctrl.dac_sleep;
    assign bit_out_o   = ctrl.bit_out;
    assign div2_o      = ctrl.div2;
    assign ramp_o      = ctrl.ramp;

endmodule

// File: rtl/cwl_checker.sv
module cwl_checker
    import cwl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               apply,
    input logic [WORD_W-1:0]  word,
    input logic [FREQ_W-1:0]  freq0,
    input logic [FREQ_W-1:0]  freq1,
    input logic [PHASE_W-1:0] phase0,
    input logic [PHASE_W-1:0] phase1,
    input logic               full_load,
    input logic               pend_valid,
    input logic               pend_idx
);

    logic is_freq;
    assign is_freq = (word[15] != word[14]);

    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (freq0 == '0 && freq1 == '0 && phase0 == '0 && phase1 == '0 && !pend_valid));

    assert_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !apply |=> ($stable(freq0) && $stable(freq1) && $stable(phase0) && $stable(phase1)));

    assert_single_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        apply |=> !apply);

    assert_phase0_load_R4: assert property (@(posedge clk) disable iff (rst)
        (apply && word[15:14] == 2'b11 && !word[13]) |=> phase0 == $past(word[PHASE_W-1:0]));

    assert_no_mixed_R6: assert property (@(posedge clk) disable iff (rst)
        (apply && full_load && is_freq && !(pend_valid && pend_idx == word[15]))
        |=> ($stable(freq0) && $stable(freq1) && pend_valid));

    assert_pair_done_R6: assert property (@(posedge clk) disable iff (rst)
        (apply && full_load && is_freq && pend_valid && pend_idx == word[15]) |=> !pend_valid);

    assert_ctrl_drops_half_R10: assert property (@(posedge clk) disable iff (rst)
        (apply && word[15:14] == 2'b00) |=> !pend_valid);

endmodule

bind cmdword_loader cwl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .apply      (apply),
    .word       (core_word),
    .freq0      (freq0_o),
    .freq1      (freq1_o),
    .phase0     (phase0_o),
    .phase1     (phase1_o),
    .full_load  (full_load_o),
    .pend_valid (pend_valid),
    .pend_idx   (pend_idx)
);

// File: tb/sim_cmdword_loader.sv
module sim_cmdword_loader;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b1;
    logic ser_frame_n = 1'b0;
    logic ser_data = 1'b0;
    logic [27:0] freq0_o, freq1_o;
    logic [11:0] phase0_o, phase1_o;
    logic full_load_o, hi_half_o, freq_sel_o, phase_sel_o, core_rst_o;
    logic clk_sleep_o, dac_sleep_o, bit_out_o, div2_o, ramp_o;

    always #10 clk = ~clk;

    cmdword_loader u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_frame_n(ser_frame_n),
        .ser_data(ser_data), .freq0_o(freq0_o), .freq1_o(freq1_o),
        .phase0_o(phase0_o), .phase1_o(phase1_o), .full_load_o(full_load_o),
        .hi_half_o(hi_half_o), .freq_sel_o(freq_sel_o), .phase_sel_o(phase_sel_o),
        .core_rst_o(core_rst_o), .clk_sleep_o(clk_sleep_o), .dac_sleep_o(dac_sleep_o),
        .bit_out_o(bit_out_o), .div2_o(div2_o), .ramp_o(ramp_o)
    );

    typedef struct {
        logic [27:0] f0, f1;
        logic [11:0] p0, p1;
        logic [9:0]  c;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state, rebuilt from the requirements
    logic [27:0] m_f0 = '0, m_f1 = '0;
    logic [11:0] m_p0 = '0, m_p1 = '0;
    logic [15:0] m_ctl = '0;
    logic        m_pv = 1'b0, m_pi = 1'b0;
    logic [13:0] m_plo = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] ctl_fields(input logic [15:0] w);
        return {w[13], w[12], w[11], w[10], w[8], w[7], w[6], w[5], w[3], w[1]};
    endfunction

    task automatic model_apply(input logic [15:0] w);
        logic idx;
        idx = w[15];
        case (w[15:14])
            2'b00: begin m_ctl = w; m_pv = 1'b0; end
            2'b11: if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
            default: begin
                if (m_ctl[13]) begin
                    if (m_pv && m_pi == idx) begin
                        if (idx) m_f1 = {w[13:0], m_plo}; else m_f0 = {w[13:0], m_plo};
                        m_pv = 1'b0;
                    end else begin
                        m_plo = w[13:0]; m_pi = idx; m_pv = 1'b1;
                    end
                end else if (m_ctl[12]) begin
                    if (idx) m_f1[27:14] = w[13:0]; else m_f0[27:14] = w[13:0];
                end else begin
                    if (idx) m_f1[13:0] = w[13:0]; else m_f0[13:0] = w[13:0];
                end
            end
        endcase
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.f0 = m_f0; e.f1 = m_f1; e.p0 = m_p0; e.p1 = m_p1;
        e.c = ctl_fields(m_ctl); e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic clock_bits(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) begin
            ser_data = w[i];
            #40 ser_clk = 1'b0;
            #50 ser_clk = 1'b1;
            #10;
        end
    endtask

    task automatic send_word(input logic [15:0] w, input string tag);
        clock_bits(w, 16);
        model_apply(w);
        push(tag);
    endtask

    task automatic frame_open();
        ser_frame_n = 1'b0;
        #50;
    endtask

    task automatic frame_close();
        #50 ser_frame_n = 1'b1;
        #100;
    endtask

    task automatic one_word(input logic [15:0] w, input string tag);
        frame_open();
        send_word(w, tag);
        frame_close();
    endtask

    // monitor: compare once the word has had time to cross (R13)
    initial begin
        exp_t e;
        forever begin
            wait (sb.size() != 0);
            e = sb.pop_front();
            repeat (6) @(negedge clk);
            chk(freq0_o == e.f0, {e.tag, " freq0"}, 32'(freq0_o), 32'(e.f0));
            chk(freq1_o == e.f1, {e.tag, " freq1"}, 32'(freq1_o), 32'(e.f1));
            chk(phase0_o == e.p0, {e.tag, " phase0"}, 32'(phase0_o), 32'(e.p0));
            chk(phase1_o == e.p1, {e.tag, " phase1"}, 32'(phase1_o), 32'(e.p1));
            chk({full_load_o, hi_half_o, freq_sel_o, phase_sel_o, core_rst_o, clk_sleep_o,
                 dac_sleep_o, bit_out_o, div2_o, ramp_o} == e.c, {e.tag, " ctrl"},
                32'({full_load_o, hi_half_o, freq_sel_o, phase_sel_o, core_rst_o, clk_sleep_o,
                     dac_sleep_o, bit_out_o, div2_o, ramp_o}), 32'(e.c));
        end
    end

    initial begin
        #5 ser_frame_n = 1'b1;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk({freq0_o, freq1_o, phase0_o, phase1_o} == '0, "R1 reset regs", 32'(freq0_o | freq1_o), 32'h0);
        chk({full_load_o, hi_half_o, ramp_o, core_rst_o} == '0, "R1 reset ctrl", 32'({full_load_o, ramp_o}), 32'h0);

        // R6 and R3: paired load inside one frame
        frame_open();
        send_word(16'h2000, "R5 paired on");
        send_word(16'h4000 | 16'h1234, "R6 first half no change");
        send_word(16'h4000 | 16'h0ABC, "R6 pair complete R3");
        frame_close();

        // R8: upper-half select ignored in paired mode
        frame_open();
        send_word(16'h3000, "R8 ctrl");
        send_word(16'h8000 | 16'h0111, "R8 first");
        send_word(16'h8000 | 16'h2222, "R8 second");
        frame_close();

        // R11: address switch restarts the pair
        frame_open();
        send_word(16'h4005, "R11 stage f0");
        send_word(16'h8006, "R11 restage f1");
        send_word(16'h8007, "R11 f1 complete");
        frame_close();

        // R12: phase write keeps staged half
        frame_open();
        send_word(16'h4001, "R12 stage");
        send_word(16'hC000 | 16'h0ABC, "R12 phase0");
        send_word(16'h4002, "R12 complete");
        frame_close();

        // R10: control write drops staged half
        frame_open();
        send_word(16'h4003, "R10 stage");
        send_word(16'h2000, "R10 ctrl");
        send_word(16'h4004, "R10 new first");
        send_word(16'h4005, "R10 complete");
        frame_close();

        // R7: split mode, upper then lower
        one_word(16'h1000, "R7 ctrl upper");
        one_word(16'h4000 | 16'h3FFF, "R7 f0 upper");
        one_word(16'h0000, "R7 ctrl lower");
        one_word(16'h8000 | 16'h1555, "R7 f1 lower");

        // R4: phase addressing with bit 12 set
        one_word(16'hF123, "R4 phase1");
        one_word(16'hD456, "R4 phase0");

        // R5: every field, then reserved bits only
        one_word(16'h0DEA, "R5 all fields");
        one_word(16'h0215, "R5 reserved bits");

        // R2: edges with strobe high change nothing
        clock_bits(16'h7FFF, 16);
        push("R2 strobe high ignored");

        // R9: aborted partial word
        frame_open();
        clock_bits(16'h7FFF, 7);
        frame_close();
        push("R9 partial dropped");
        one_word(16'h5ABC, "R9 R2 next word intact");

        wait (sb.size() == 0);
        repeat (12) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R13 act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule